// File: doc/BRIEF.md
# Hoisted-Load Alias Guard

This block tracks loads that a compiler has moved above earlier stores whose addresses were not known to differ. When such a load issues, it records its destination register together with the byte range it read. Every store that executes afterwards is compared against all recorded ranges, and any entry whose bytes it touches is dropped. Before the speculative value is used, a check names the register. The block answers in the next cycle with a hit if the entry survived. On a miss it raises a poison indication for that register so that recovery code can reload it.

The table has `ENTRIES` fully associative slots. A new register takes the slot under a round-robin pointer. An insert for a register that already has a live slot reuses that slot instead. Each slot is a two-state machine, `ENT_EMPTY` and `ENT_LIVE`:
- EMPTY goes to LIVE on a write.
- LIVE goes to EMPTY on an overlapping store, on a check-and-clear hit, or on clear-all.
- LIVE stays LIVE on a rewrite.

The check responder is a three-state machine. It is in `RSP_IDLE` when no check was made in the previous cycle. It moves to `RSP_HIT` or `RSP_MISS` in the cycle after a check, depending on whether a live slot held the register. It falls back to `RSP_IDLE` when no check follows. The clear-all input is meant for context switches.

Top module: `hoist_guard`

## Requirements
- R1: After reset no slot is live, and `chk_done`, `chk_hit` and `poison_valid` are low.
- R2: A check of a register inserted in an earlier cycle and not since invalidated gives `chk_done`=1 and `chk_hit`=1 in the cycle after `chk_valid`.
- R3: An insert of a register with no live slot writes the slot under a round-robin pointer. The pointer starts at 0 and advances by one, wrapping after `ENTRIES`-1. The register previously held in that slot then misses on check.
- R4: A store invalidates every live slot whose byte range [addr, addr+n) overlaps the store's range. The size code gives n: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A store ending exactly where a slot begins, or starting where it ends, leaves the slot live.
- R5: An insert of a register that already has a live slot overwrites that slot's address and size. The old range is then no longer tracked.
- R6: A check that misses gives `chk_done`=1, `chk_hit`=0, `poison_valid`=1 and `poison_reg` equal to the checked register. A hit leaves `poison_valid` low.
- R7: When a store and an insert occur in the same cycle and the store overlaps the inserted range, the new entry survives.
- R8: A check with `chk_clear`=1 that hits removes the slot, so a later check of that register misses. A check with `chk_clear`=0 leaves the slot live.
- R9: `clr_all` invalidates every slot. It overrides a same-cycle insert, and the round-robin pointer does not advance in that cycle.
- R10: A check reports the table as it stood before the same cycle's store, insert or clear took effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Invalidate all slots |
| ins_valid | input | 1 | Hoisted load insert |
| ins_reg | input | REG_W | Destination register of the load |
| ins_addr | input | ADDR_W | Load byte address |
| ins_size | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| st_valid | input | 1 | Store snoop valid |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check request |
| chk_reg | input | REG_W | Register to check |
| chk_clear | input | 1 | Remove the slot on hit |
| chk_done | output | 1 | Check response valid (cycle after request) |
| chk_hit | output | 1 | Slot was live |
| poison_valid | output | 1 | Checked register must be recovered |
| poison_reg | output | REG_W | Register to recover |

## Verification
The bench builds the block with its defaults: 16 slots, 7-bit register numbers and 32-bit addresses. With 16 slots, seventeen distinct inserts wrap the round-robin pointer and evict the first register. The 32-bit addresses let directed cases place stores one byte before and one byte after a tracked range, at every size code. A random phase draws addresses from a 64-byte window and registers from a small set. This keeps overlaps, reuses, same-cycle collisions and evictions frequent.

// File: rtl/hg_pkg.sv
package hg_pkg;
    typedef enum logic {
        ENT_EMPTY,
        ENT_LIVE
    } ent_state_t;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_HIT,
        RSP_MISS
    } rsp_state_t;

    localparam int SZ_W = 2;

    function automatic logic [3:0] span_bytes(input logic [SZ_W-1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/hg_entry.sv
module hg_entry
    import hg_pkg::*;
#(
    parameter int REG_W  = 7,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [REG_W-1:0]  new_reg,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [SZ_W-1:0]   new_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZ_W-1:0]   st_size,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_kill,
    output logic              live,
    output logic              ins_match,
    output logic              chk_match
);
    localparam int EXT_W = ADDR_W + 1;

    ent_state_t        state, state_nxt;
    logic [REG_W-1:0]  tag_reg;
    logic [ADDR_W-1:0] tag_addr;
    logic [SZ_W-1:0]   tag_size;
    logic [EXT_W-1:0]  e_lo, e_end, s_lo, s_end;
    logic              st_overlap;

    always_comb begin
        e_lo       = {1'b0, tag_addr};
        e_end      = e_lo + EXT_W'(span_bytes(tag_size));
        s_lo       = {1'b0, st_addr};
        s_end      = s_lo + EXT_W'(span_bytes(st_size));
        st_overlap = st_valid && (s_lo < e_end) && (e_lo < s_end);
    end

    // next state: clear beats write, write beats any kill
    always_comb begin
        state_nxt = state;
        if (clr) begin
            state_nxt = ENT_EMPTY;
        end else if (wr) begin
            state_nxt = ENT_LIVE;
        end else begin
            unique case (state)
                ENT_EMPTY: state_nxt = ENT_EMPTY;
                ENT_LIVE:  if (st_overlap || chk_kill) state_nxt = ENT_EMPTY;
                default:   state_nxt = ENT_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENT_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_reg  <= '0;
            tag_addr <= '0;
            tag_size <= '0;
        end else if (wr && !clr) begin
            tag_reg  <= new_reg;
            tag_addr <= new_addr;
            tag_size <= new_size;
        end
    end

    always_comb begin
        live      = (state == ENT_LIVE);
        ins_match = live && (tag_reg == new_reg);
        chk_match = live && (tag_reg == chk_reg);
    end

    // R4: an overlapping store with no rescuing write empties the slot
    p_store_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && st_overlap && !wr && !clr) |=> !live);
endmodule

// File: rtl/hg_victim.sv
module hg_victim #(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc,
    output logic [ENTRIES-1:0] onehot
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (alloc) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_dec
        assign onehot[gi] = (ptr == IDX_W'(gi));
    end

    // R3: each allocation steps the pointer by one with wrap
    p_victim_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
endmodule

// File: rtl/hg_lookup.sv
module hg_lookup
    import hg_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chk_valid,
    input  logic [REG_W-1:0]   chk_reg,
    input  logic               chk_clear,
    input  logic [ENTRIES-1:0] chk_match,
    output logic [ENTRIES-1:0] chk_kill,
    output logic               chk_done,
    output logic               chk_hit,
    output logic               poison_valid,
    output logic [REG_W-1:0]   poison_reg
);
    rsp_state_t       state, state_nxt;
    logic [REG_W-1:0] reg_q;

    always_comb begin
        state_nxt = RSP_IDLE;
        unique case (state)
            RSP_IDLE, RSP_HIT, RSP_MISS: begin
                if (chk_valid) state_nxt = (|chk_match) ? RSP_HIT : RSP_MISS;
                else           state_nxt = RSP_IDLE;
            end
            default: state_nxt = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RSP_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         reg_q <= '0;
        else if (chk_valid) reg_q <= chk_reg;
    end

    always_comb begin
        chk_kill     = (chk_valid && chk_clear) ? chk_match : '0;
        chk_done     = (state != RSP_IDLE);
        chk_hit      = (state == RSP_HIT);
        poison_valid = (state == RSP_MISS);
        poison_reg   = reg_q;
    end

    // R2: every request is answered in the following cycle
    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_done);
    // R8: a register never matches two live slots
    p_chk_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_match));
endmodule

// File: rtl/hoist_guard.sv
module hoist_guard
    import hg_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int REG_W   = 7,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              ins_valid,
    input  logic [REG_W-1:0]  ins_reg,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [1:0]        ins_size,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    input  logic              chk_clear,
    output logic              chk_done,
    output logic              chk_hit,
    output logic              poison_valid,
    output logic [REG_W-1:0]  poison_reg
);
    logic [ENTRIES-1:0] live_vec, ins_match, chk_match, chk_kill, victim, wr_sel;
    logic               reuse, alloc;

    always_comb begin
        reuse  = |ins_match;
        alloc  = ins_valid && !clr_all && !reuse;
        wr_sel = (ins_valid && !clr_all) ? (reuse ? ins_match : victim) : '0;
    end

    hg_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .alloc  (alloc),
        .onehot (victim)
    );

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
        hg_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr_all),
            .wr        (wr_sel[gi]),
            .new_reg   (ins_reg),
            .new_addr  (ins_addr),
            .new_size  (ins_size),
            .st_valid  (st_valid),
            .st_addr   (st_addr),
            .st_size   (st_size),
            .chk_reg   (chk_reg),
            .chk_kill  (chk_kill[gi]),
            .live      (live_vec[gi]),
            .ins_match (ins_match[gi]),
            .chk_match (chk_match[gi])
        );
    end

    hg_lookup #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_lookup (
        .clk          (clk),
        .rst_n        (rst_n),
        .chk_valid    (chk_valid),
        .chk_reg      (chk_reg),
        .chk_clear    (chk_clear),
        .chk_match    (chk_match),
        .chk_kill     (chk_kill),
        .chk_done     (chk_done),
        .chk_hit      (chk_hit),
        .poison_valid (poison_valid),
        .poison_reg   (poison_reg)
    );

    // R9: clear-all leaves no slot live
    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (live_vec == '0));
    // R5: a register is held by at most one slot, so reuse is unambiguous
    p_ins_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ins_match));
endmodule

// File: tb/hoist_guard_test.sv
`timescale 1ns/1ps
module hoist_guard_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_all = 0, ins_valid = 0, st_valid = 0, chk_valid = 0, chk_clear = 0;
    logic [6:0]  ins_reg = 0, chk_reg = 0;
    logic [31:0] ins_addr = 0, st_addr = 0;
    logic [1:0]  ins_size = 0, st_size = 0;
    logic        chk_done, chk_hit, poison_valid;
    logic [6:0]  poison_reg;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    bit          m_live [N];
    logic [6:0]  m_reg  [N];
    longint      m_addr [N];
    int          m_size [N];
    int          m_ptr = 0;

    bit    q_hit [$];
    logic [6:0] q_reg [$];
    string q_tag [$];

    always #2.5 clk = ~clk;

    hoist_guard uut (
        .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
        .ins_valid(ins_valid), .ins_reg(ins_reg), .ins_addr(ins_addr), .ins_size(ins_size),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
        .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_clear(chk_clear),
        .chk_done(chk_done), .chk_hit(chk_hit),
        .poison_valid(poison_valid), .poison_reg(poison_reg)
    );

    function automatic bit ovl(longint a0, int ac, longint b0, int bc);
        longint an = 64'd1 << ac;
        longint bn = 64'd1 << bc;
        return (a0 < b0 + bn) && (b0 < a0 + an);
    endfunction

    task automatic expect_eq(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit iv, logic [6:0] ir, logic [31:0] ia, logic [1:0] isz,
                        bit sv, logic [31:0] sa, logic [1:0] ssz,
                        bit cv, logic [6:0] cr, bit cc, bit ca, string tag);
        int tgt;
        bit hit, al;
        @(negedge clk);
        ins_valid = iv; ins_reg = ir; ins_addr = ia; ins_size = isz;
        st_valid = sv; st_addr = sa; st_size = ssz;
        chk_valid = cv; chk_reg = cr; chk_clear = cc; clr_all = ca;
        if (cv) begin
            hit = 0;
            for (int e = 0; e < N; e++) if (m_live[e] && m_reg[e] == cr) hit = 1;
            q_hit.push_back(hit); q_reg.push_back(cr); q_tag.push_back(tag);
        end
        if (ca) begin
            for (int e = 0; e < N; e++) m_live[e] = 0;
        end else begin
            tgt = -1; al = 0;
            if (iv) begin
                for (int e = 0; e < N; e++) if (m_live[e] && m_reg[e] == ir) tgt = e;
                if (tgt < 0) begin al = 1; tgt = m_ptr; end
            end
            if (sv) for (int e = 0; e < N; e++)
                if (m_live[e] && e != tgt && ovl(m_addr[e], m_size[e], longint'(sa), int'(ssz)))
                    m_live[e] = 0;
            if (cv && cc) for (int e = 0; e < N; e++)
                if (m_live[e] && e != tgt && m_reg[e] == cr) m_live[e] = 0;
            if (iv) begin
                m_live[tgt] = 1; m_reg[tgt] = ir; m_addr[tgt] = longint'(ia); m_size[tgt] = int'(isz);
                if (al) m_ptr = (m_ptr + 1) % N;
            end
        end
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic ins(logic [6:0] r, logic [31:0] a, logic [1:0] s);
        step(1, r, a, s, 0, 0, 0, 0, 0, 0, 0, "");
    endtask
    task automatic st(logic [31:0] a, logic [1:0] s);
        step(0, 0, 0, 0, 1, a, s, 0, 0, 0, 0, "");
    endtask
    task automatic chk(logic [6:0] r, bit c, string tag);
        step(0, 0, 0, 0, 0, 0, 0, 1, r, c, 0, tag);
    endtask

    // monitor: compares each response against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (chk_done) begin
                if (q_hit.size() == 0) begin
                    expect_eq("R2", "unexpected chk_done", 1, 0);
                end else begin
                    automatic bit eh = q_hit.pop_front();
                    automatic logic [6:0] er = q_reg.pop_front();
                    automatic string t = q_tag.pop_front();
                    expect_eq(t, "chk_hit", chk_hit, eh);
                    expect_eq("R6", "poison_valid", poison_valid, !eh);
                    if (!eh) expect_eq("R6", "poison_reg", poison_reg, er);
                end
            end else begin
                if (poison_valid) expect_eq("R6", "poison without done", 1, 0);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < N; e++) begin m_live[e] = 0; m_reg[e] = 0; m_addr[e] = 0; m_size[e] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        expect_eq("R1", "chk_done", chk_done, 0);
        expect_eq("R1", "chk_hit", chk_hit, 0);
        expect_eq("R1", "poison_valid", poison_valid, 0);
        chk(7'd3, 0, "R1");
        // R2: insert then check
        ins(7'd5, 32'h100, 2'd2);
        chk(7'd5, 0, "R2");
        // R6: unknown register misses and poisons
        chk(7'd9, 0, "R6");
        // R4: adjacent stores keep, overlapping store kills
        st(32'h104, 2'd2);
        st(32'h0FF, 2'd0);
        st(32'h0F8, 2'd3);
        chk(7'd5, 0, "R4");
        st(32'h103, 2'd0);
        chk(7'd5, 0, "R4");
        ins(7'd6, 32'h100, 2'd1);
        st(32'h0FC, 2'd3);
        chk(7'd6, 0, "R4");
        ins(7'd11, 32'h180, 2'd3);
        st(32'h187, 2'd1);
        chk(7'd11, 0, "R4");
        // R5: overwrite moves the tracked range
        ins(7'd7, 32'h200, 2'd2);
        ins(7'd7, 32'h300, 2'd2);
        st(32'h200, 2'd2);
        chk(7'd7, 0, "R5");
        st(32'h302, 2'd0);
        chk(7'd7, 0, "R5");
        // R7: same-cycle insert and overlapping store
        step(1, 7'd8, 32'h400, 2'd2, 1, 32'h400, 2'd2, 0, 0, 0, 0, "");
        chk(7'd8, 0, "R7");
        ins(7'd12, 32'h500, 2'd2);
        step(1, 7'd12, 32'h600, 2'd1, 1, 32'h600, 2'd0, 0, 0, 0, 0, "");
        chk(7'd12, 0, "R7");
        // R8: check without clear keeps, with clear removes
        chk(7'd8, 0, "R8");
        chk(7'd8, 1, "R8");
        chk(7'd8, 0, "R8");
        // R10: check sees state before same-cycle store
        ins(7'd13, 32'h700, 2'd0);
        step(0, 0, 0, 0, 1, 32'h700, 2'd0, 1, 7'd13, 0, 0, "R10");
        chk(7'd13, 0, "R10");
        // R9: clear-all wins over insert
        ins(7'd14, 32'h800, 2'd2);
        step(1, 7'd15, 32'h900, 2'd2, 0, 0, 0, 0, 0, 0, 1, "");
        chk(7'd14, 0, "R9");
        chk(7'd15, 0, "R9");
        // R3: seventeen allocations evict the first
        for (int i = 0; i < 17; i++) ins(7'(40 + i), 32'h1000 + 32'(i * 16), 2'd2);
        chk(7'd40, 0, "R3");
        chk(7'd41, 0, "R3");
        chk(7'd56, 0, "R3");
        // random mix against the model
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 1), 7'($urandom_range(0, 20)), 32'h2000 + 32'($urandom_range(0, 63)),
                 2'($urandom_range(0, 3)),
                 $urandom_range(0, 2) == 0, 32'h2000 + 32'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
                 $urandom_range(0, 1), 7'($urandom_range(0, 20)), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 60) == 0, "R10");
        end
        idle(); idle(); idle();
        expect_eq("R2", "pending responses", q_hit.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule